// File: doc/BRIEF.md
# Packed Fused Multiply Alternating Add/Subtract Lane Controller

This block sits in front of a packed double-precision fused multiply-add datapath. It accepts three source vectors of up to eight 64-bit lanes, together with the mode fields of one operation. It chooses which source feeds the multiplicand, the multiplier and the addend of every lane. It flips the addend sign on even lanes, so the arithmetic core only ever adds. It also selects the rounding mode for the core. When the core returns its per-lane results, the block builds the destination vector. It applies the write mask in merge or zero style, and it clears every lane above the selected vector length.

The controller has two register stages. The first captures the operation and presents the steered operands to the core. The core must return its results within that same cycle. The second stage registers the destination vector. A valid flag travels with the data, and the latency is two cycles in every mode.

Top module: `fmas_lane_ctrl`

## Requirements
- R1: Operand order code 0 multiplies dest by src3 and uses src2 as addend. Code 1 multiplies src2 by dest and uses src3 as addend. Code 2, and the unused code 3, multiply src2 by src3 and use dest as addend.
- R2: In even lanes (0, 2, 4, 6) the result is product minus addend, and the block flips bit 63 of the addend it sends to the core. In odd lanes the result is product plus addend, and the addend goes to the core unchanged.
- R3: Length code 0 gives 2 active lanes (128 bits), code 1 gives 4 lanes (256 bits), and code 2 or 3 gives 8 lanes (512 bits).
- R4: When masking is in use and a lane's mask bit (bit j for lane j) is 0, merge style (zero flag 0) keeps the old dest lane and zero style (zero flag 1) writes 0.
- R5: When the no-mask flag is 1, every active lane is written whatever the mask bits and the zero flag hold.
- R6: Every destination bit at or above the active vector length is 0, in all masking styles.
- R7: When the third source comes from memory and the broadcast flag is 1, every lane uses src3 bits 63:0 in place of its own src3 lane.
- R8: The rounding code is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The embedded field is used when the third source is a register, the broadcast flag is 1 and the length is 512 bits. In every other case the global field is used.
- R9: In legacy 128-bit mode, only lanes 0 and 1 are computed. The mask, the zero flag and the broadcast flag are ignored, the global rounding field is used, and all higher bits are 0.
- R10: fmaValid follows inValid by one cycle and wbValid follows fmaValid by one cycle. Both are 0 after reset, and the destination register resets to 0.
- R11: Lanes outside the active length drive zero multiplicand, multiplier and addend to the core, and their lane-enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present on the inputs |
| srcDest | input | 512 | Destination / first source vector |
| srcTwo | input | 512 | Second source vector |
| srcThree | input | 512 | Third source vector |
| orderSel | input | 2 | Operand order: 0, 1, 2 (3 acts as 2) |
| lenSel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| legacyEnc | input | 1 | Legacy 128-bit encoding |
| maskBits | input | 8 | Per-lane write mask |
| noMask | input | 1 | Ignore the mask; write every active lane |
| zeroMode | input | 1 | 1 = zero unwritten lanes, 0 = merge |
| bcastFlag | input | 1 | Broadcast / embedded-rounding flag |
| memSrc | input | 1 | Third source is a memory operand |
| embRound | input | 2 | Embedded rounding field |
| globalRound | input | 2 | Global rounding control field |
| fmaValid | output | 1 | Operands valid to the core |
| fmaMulA | output | 512 | Per-lane multiplicand |
| fmaMulB | output | 512 | Per-lane multiplier |
| fmaAddend | output | 512 | Per-lane sign-adjusted addend |
| fmaRound | output | 2 | Rounding code to the core |
| fmaLaneEn | output | 8 | Lanes whose result will be written |
| fmaResult | input | 512 | Per-lane core results, same cycle as fmaValid |
| wbValid | output | 1 | Destination vector valid |
| wbData | output | 512 | Destination vector |

## Verification
The bench builds the block with its package defaults: 64-bit lanes and eight lanes, which is the full 512-bit width. With those values all three length codes, all eight mask bits and the highest-lane clearing paths can be reached. The core is modelled in the bench with real arithmetic on small integers, so every expected lane value is exact. The operand order, lane parity, broadcast and masking combinations can then be compared bit for bit.

// File: rtl/fmas_pkg.sv
package fmas_pkg;
  localparam int LANE_W = 64;
  localparam int LANES  = 8;
  localparam int VEC_W  = LANE_W * LANES;
  localparam int LEN_W  = 2;

  typedef enum logic [1:0] {
    ORD_132 = 2'd0,
    ORD_213 = 2'd1,
    ORD_231 = 2'd2
  } ordSel_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } rndMode_e;

  typedef struct packed {
    logic [LANES-1:0] laneActive;
    logic [LANES-1:0] laneWrite;
    logic             zeroFill;
    logic             bcastSel;
    ordSel_e          order;
    rndMode_e         rnd;
  } ctrlStrb_t;
endpackage

// File: rtl/fmas_ctrl.sv
module fmas_ctrl
  import fmas_pkg::*;
(
  input  logic [1:0]       orderSel,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             legacyEnc,
  input  logic [LANES-1:0] maskBits,
  input  logic             noMask,
  input  logic             zeroMode,
  input  logic             bcastFlag,
  input  logic             memSrc,
  input  logic [1:0]       embRound,
  input  logic [1:0]       globalRound,
  output ctrlStrb_t        strb
);
  logic [LEN_W-1:0] lenEff;
  logic             useMask;
  logic [LANES-1:0] activeVec;
  logic [LANES-1:0] writeVec;
  logic             useEmb;

  always_comb begin
    if (legacyEnc)          lenEff = '0;
    else if (lenSel > 2'd2) lenEff = 2'd2;
    else                    lenEff = lenSel;
  end

  assign useMask = !legacyEnc && !noMask;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign activeVec[j] = (32'(j) < (32'd2 << lenEff));
    assign writeVec[j]  = activeVec[j] && (!useMask || maskBits[j]);
  end

  assign useEmb = !legacyEnc && !memSrc && bcastFlag && (lenEff == 2'd2);

  always_comb begin
    strb.laneActive = activeVec;
    strb.laneWrite  = writeVec;
    strb.zeroFill   = useMask && zeroMode;
    strb.bcastSel   = !legacyEnc && memSrc && bcastFlag;
    case (orderSel)
      2'd0:    strb.order = ORD_132;
      2'd1:    strb.order = ORD_213;
      default: strb.order = ORD_231;
    endcase
    strb.rnd = useEmb ? rndMode_e'(embRound) : rndMode_e'(globalRound);
  end
endmodule

// File: rtl/fmas_datapath.sv
module fmas_datapath
  import fmas_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  ctrlStrb_t        strbIn,
  input  logic [VEC_W-1:0] srcDest,
  input  logic [VEC_W-1:0] srcTwo,
  input  logic [VEC_W-1:0] srcThree,
  output logic             fmaValid,
  output logic [VEC_W-1:0] fmaMulA,
  output logic [VEC_W-1:0] fmaMulB,
  output logic [VEC_W-1:0] fmaAddend,
  output logic [1:0]       fmaRound,
  output logic [LANES-1:0] fmaLaneEn,
  input  logic [VEC_W-1:0] fmaResult,
  output logic             wbValid,
  output logic [VEC_W-1:0] wbData
);
  logic             s1Valid;
  ctrlStrb_t        s1Strb;
  logic [VEC_W-1:0] s1Dest, s1Two, s1Three;
  logic [VEC_W-1:0] wbNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Strb  <= '0;
      s1Dest  <= '0;
      s1Two   <= '0;
      s1Three <= '0;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Strb  <= strbIn;
        s1Dest  <= srcDest;
        s1Two   <= srcTwo;
        s1Three <= srcThree;
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] dLane, twoLane, threeLane;
    logic [LANE_W-1:0] opA, opB, opC, opCAdj;

    assign dLane     = s1Dest[j*LANE_W +: LANE_W];
    assign twoLane   = s1Two[j*LANE_W +: LANE_W];
    assign threeLane = s1Strb.bcastSel ? s1Three[LANE_W-1:0]
                                       : s1Three[j*LANE_W +: LANE_W];

    always_comb begin
      case (s1Strb.order)
        ORD_132: begin opA = dLane;   opB = threeLane; opC = twoLane;   end
        ORD_213: begin opA = twoLane; opB = dLane;     opC = threeLane; end
        default: begin opA = twoLane; opB = threeLane; opC = dLane;     end
      endcase
    end

    if ((j % 2) == 0) begin : g_even
      assign opCAdj = {~opC[LANE_W-1], opC[LANE_W-2:0]};
    end else begin : g_odd
      assign opCAdj = opC;
    end

    assign fmaMulA[j*LANE_W +: LANE_W]   = s1Strb.laneActive[j] ? opA    : '0;
    assign fmaMulB[j*LANE_W +: LANE_W]   = s1Strb.laneActive[j] ? opB    : '0;
    assign fmaAddend[j*LANE_W +: LANE_W] = s1Strb.laneActive[j] ? opCAdj : '0;

    always_comb begin
      if (!s1Strb.laneActive[j])
        wbNext[j*LANE_W +: LANE_W] = '0;
      else if (s1Strb.laneWrite[j])
        wbNext[j*LANE_W +: LANE_W] = fmaResult[j*LANE_W +: LANE_W];
      else if (s1Strb.zeroFill)
        wbNext[j*LANE_W +: LANE_W] = '0;
      else
        wbNext[j*LANE_W +: LANE_W] = dLane;
    end
  end

  assign fmaValid  = s1Valid;
  assign fmaRound  = s1Strb.rnd;
  assign fmaLaneEn = s1Strb.laneWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbData  <= '0;
    end else begin
      wbValid <= s1Valid;
      if (s1Valid) wbData <= wbNext;
    end
  end
endmodule

// File: rtl/fmas_lane_ctrl.sv
module fmas_lane_ctrl
  import fmas_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcDest,
  input  logic [VEC_W-1:0] srcTwo,
  input  logic [VEC_W-1:0] srcThree,
  input  logic [1:0]       orderSel,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             legacyEnc,
  input  logic [LANES-1:0] maskBits,
  input  logic             noMask,
  input  logic             zeroMode,
  input  logic             bcastFlag,
  input  logic             memSrc,
  input  logic [1:0]       embRound,
  input  logic [1:0]       globalRound,
  output logic             fmaValid,
  output logic [VEC_W-1:0] fmaMulA,
  output logic [VEC_W-1:0] fmaMulB,
  output logic [VEC_W-1:0] fmaAddend,
  output logic [1:0]       fmaRound,
  output logic [LANES-1:0] fmaLaneEn,
  input  logic [VEC_W-1:0] fmaResult,
  output logic             wbValid,
  output logic [VEC_W-1:0] wbData
);
  ctrlStrb_t strb;

  fmas_ctrl ctrl_i (
    .orderSel(orderSel), .lenSel(lenSel), .legacyEnc(legacyEnc),
    .maskBits(maskBits), .noMask(noMask), .zeroMode(zeroMode),
    .bcastFlag(bcastFlag), .memSrc(memSrc), .embRound(embRound),
    .globalRound(globalRound), .strb(strb)
  );

  fmas_datapath dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strbIn(strb),
    .srcDest(srcDest), .srcTwo(srcTwo), .srcThree(srcThree),
    .fmaValid(fmaValid), .fmaMulA(fmaMulA), .fmaMulB(fmaMulB),
    .fmaAddend(fmaAddend), .fmaRound(fmaRound), .fmaLaneEn(fmaLaneEn),
    .fmaResult(fmaResult), .wbValid(wbValid), .wbData(wbData)
  );
endmodule

// File: rtl/fmas_lane_ctrl_chk.sv
module fmas_lane_ctrl_chk
  import fmas_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] srcDest,
  input logic [1:0]       orderSel,
  input logic [LEN_W-1:0] lenSel,
  input logic             legacyEnc,
  input logic [LANES-1:0] maskBits,
  input logic             noMask,
  input logic             zeroMode,
  input logic             bcastFlag,
  input logic             memSrc,
  input logic [1:0]       embRound,
  input logic [1:0]       globalRound,
  input logic             fmaValid,
  input logic [VEC_W-1:0] fmaAddend,
  input logic [1:0]       fmaRound,
  input logic [LANES-1:0] fmaLaneEn,
  input logic             wbValid,
  input logic [VEC_W-1:0] wbData
);
  a_r10_stage1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> fmaValid);
  a_r10_stage2: assert property (@(posedge clk) disable iff (!rstN)
    fmaValid |=> wbValid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !fmaValid |=> !wbValid);

  a_r9_legacy: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && legacyEnc) |->
      (fmaLaneEn[LANES-1:2] == '0) && (fmaRound == $past(globalRound)));

  a_r8_embedded: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !legacyEnc && !memSrc && bcastFlag && (lenSel >= 2'd2))
      |-> fmaRound == $past(embRound));

  a_r5_nomask: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !legacyEnc && noMask && (lenSel >= 2'd2)) |-> (&fmaLaneEn));

  a_r2_sign: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !legacyEnc && (orderSel == 2'd2)) |->
      (fmaAddend[LANE_W-1] != $past(srcDest[LANE_W-1])) &&
      (fmaAddend[2*LANE_W-1] == $past(srcDest[2*LANE_W-1])));

  a_r4_zero_lane0: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !legacyEnc && !noMask && zeroMode && !maskBits[0], 2)
      |-> wbData[LANE_W-1:0] == '0);

  a_r6_upper: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && (legacyEnc || (lenSel == 2'd0)), 2)
      |-> wbData[VEC_W-1:2*LANE_W] == '0);
endmodule

bind fmas_lane_ctrl fmas_lane_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcDest(srcDest),
  .orderSel(orderSel), .lenSel(lenSel), .legacyEnc(legacyEnc),
  .maskBits(maskBits), .noMask(noMask), .zeroMode(zeroMode),
  .bcastFlag(bcastFlag), .memSrc(memSrc), .embRound(embRound),
  .globalRound(globalRound), .fmaValid(fmaValid), .fmaAddend(fmaAddend),
  .fmaRound(fmaRound), .fmaLaneEn(fmaLaneEn), .wbValid(wbValid),
  .wbData(wbData)
);

// File: tb/fmas_lane_ctrl_tb_top.sv
module fmas_lane_ctrl_tb_top;
  import fmas_pkg::*;

  typedef struct packed {
    logic [1:0] ord;
    logic [1:0] len;
    logic       leg;
    logic       nom;
    logic       zer;
    logic       bc;
    logic       mem;
    logic [7:0] mask;
    logic [3:0] tag;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    {2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 order 0
    {2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 order 1
    {2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 order 2
    {2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 256
    {2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 128
    {2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 4'd4},  // R4 merge
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 4'd4},  // R4 zero
    {2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 no mask
    {2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, 4'd6},  // R6 upper clear
    {2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 broadcast
    {2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'd8},  // R8 embedded
    {2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'd8},  // R8 global
    {2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd9},  // R9 legacy
    {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h96, 4'd7}   // R7 with merge
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic [VEC_W-1:0] srcDest, srcTwo, srcThree;
  logic [1:0]       orderSel;
  logic [LEN_W-1:0] lenSel;
  logic             legacyEnc, noMask, zeroMode, bcastFlag, memSrc;
  logic [LANES-1:0] maskBits;
  logic [1:0]       embRound, globalRound;
  logic             fmaValid, wbValid;
  logic [VEC_W-1:0] fmaMulA, fmaMulB, fmaAddend, fmaResult, wbData;
  logic [1:0]       fmaRound;
  logic [LANES-1:0] fmaLaneEn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  fmas_lane_ctrl dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcDest(srcDest),
    .srcTwo(srcTwo), .srcThree(srcThree), .orderSel(orderSel),
    .lenSel(lenSel), .legacyEnc(legacyEnc), .maskBits(maskBits),
    .noMask(noMask), .zeroMode(zeroMode), .bcastFlag(bcastFlag),
    .memSrc(memSrc), .embRound(embRound), .globalRound(globalRound),
    .fmaValid(fmaValid), .fmaMulA(fmaMulA), .fmaMulB(fmaMulB),
    .fmaAddend(fmaAddend), .fmaRound(fmaRound), .fmaLaneEn(fmaLaneEn),
    .fmaResult(fmaResult), .wbValid(wbValid), .wbData(wbData)
  );

  // behavioural FMA core: exact for the small integers used here
  always_comb begin
    for (int j = 0; j < LANES; j++)
      fmaResult[j*LANE_W +: LANE_W] = $realtobits(
        $bitstoreal(fmaMulA[j*LANE_W +: LANE_W]) *
        $bitstoreal(fmaMulB[j*LANE_W +: LANE_W]) +
        $bitstoreal(fmaAddend[j*LANE_W +: LANE_W]));
  end

  function automatic logic [VEC_W-1:0] mkVec(int k, int kind);
    logic [VEC_W-1:0] v;
    for (int j = 0; j < LANES; j++) begin
      real x;
      if (kind == 0)      x = real'(j + 1 + k);
      else if (kind == 1) x = real'(j + 2);
      else                x = real'(10 + j + k);
      v[j*LANE_W +: LANE_W] = $realtobits(x);
    end
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] expWb(vec_t v, logic [VEC_W-1:0] d,
                                             logic [VEC_W-1:0] t2,
                                             logic [VEC_W-1:0] t3);
    logic [VEC_W-1:0] r;
    int  len, n;
    bit  useMask, bc;
    len = v.leg ? 0 : ((v.len > 2) ? 2 : int'(v.len));
    n = 2 << len;
    useMask = !v.leg && !v.nom;
    bc = !v.leg && v.mem && v.bc;
    for (int j = 0; j < LANES; j++) begin
      real a, b, c, x3, dv, tv, p;
      dv = $bitstoreal(d[j*LANE_W +: LANE_W]);
      tv = $bitstoreal(t2[j*LANE_W +: LANE_W]);
      x3 = bc ? $bitstoreal(t3[LANE_W-1:0]) : $bitstoreal(t3[j*LANE_W +: LANE_W]);
      case (v.ord)
        2'd0:    begin a = dv; b = x3; c = tv; end
        2'd1:    begin a = tv; b = dv; c = x3; end
        default: begin a = tv; b = x3; c = dv; end
      endcase
      p = ((j % 2) == 0) ? (a * b - c) : (a * b + c);
      if (j >= n)                        r[j*LANE_W +: LANE_W] = '0;
      else if (!useMask || v.mask[j])    r[j*LANE_W +: LANE_W] = $realtobits(p);
      else if (v.zer)                    r[j*LANE_W +: LANE_W] = '0;
      else                               r[j*LANE_W +: LANE_W] = d[j*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, int k);
    @(negedge clk);
    srcDest  = mkVec(k, 0);
    srcTwo   = mkVec(k, 1);
    srcThree = mkVec(k, 2);
    orderSel = v.ord;  lenSel = v.len;  legacyEnc = v.leg;
    noMask = v.nom;    zeroMode = v.zer; bcastFlag = v.bc;
    memSrc = v.mem;    maskBits = v.mask;
    inValid = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0;
    srcDest = '0; srcTwo = '0; srcThree = '0;
    orderSel = '0; lenSel = '0; legacyEnc = 1'b0; maskBits = '0;
    noMask = 1'b0; zeroMode = 1'b0; bcastFlag = 1'b0; memSrc = 1'b0;
    embRound = 2'b10; globalRound = 2'b01;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(!fmaValid && !wbValid, "R10", "valids after reset",
          {fmaValid, wbValid}, '0);
    check(wbData == '0, "R10", "wbData after reset", wbData, '0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [VEC_W-1:0] ev;
      logic [1:0] er;
      string tg;
      v = VECS[i];
      tg = $sformatf("R%0d", v.tag);
      drive(v, i);
      ev = expWb(v, srcDest, srcTwo, srcThree);
      er = (!v.leg && !v.mem && v.bc && v.len >= 2) ? embRound : globalRound;
      @(negedge clk);
      inValid = 1'b0;
      // R8 rounding source and R10 first stage
      check(fmaRound == er, "R8", "fmaRound", VEC_W'(fmaRound), VEC_W'(er));
      check(fmaValid, "R10", "fmaValid one cycle later", VEC_W'(fmaValid), 1);
      if (i == 0) begin
        // R2 even lane addend negated, odd lane passed
        check(fmaAddend[LANE_W-1:0] == $realtobits(-2.0), "R2", "lane0 addend",
              fmaAddend, $realtobits(-2.0));
        check(fmaAddend[2*LANE_W-1:LANE_W] == $realtobits(3.0), "R2", "lane1 addend",
              fmaAddend, $realtobits(3.0));
      end
      if (i == 4) begin
        // R11 inactive lanes quiet towards the core
        check((fmaMulA[VEC_W-1:2*LANE_W] == '0) && (fmaMulB[VEC_W-1:2*LANE_W] == '0) &&
              (fmaAddend[VEC_W-1:2*LANE_W] == '0) && (fmaLaneEn[LANES-1:2] == '0),
              "R11", "inactive lane operands", fmaMulA, '0);
      end
      @(negedge clk);
      check(wbValid, "R10", "wbValid two cycles later", VEC_W'(wbValid), 1);
      check(wbData == ev, tg, "wbData", wbData, ev);
    end

    // R10 no spurious valid when idle
    @(negedge clk);
    check(!fmaValid && !wbValid, "R10", "idle valids", {fmaValid, wbValid}, '0);

    // R8 other code values pass through unchanged
    globalRound = 2'b11; embRound = 2'b00;
    drive(VECS[11], 3);
    @(negedge clk);
    inValid = 1'b0;
    check(fmaRound == 2'b11, "R8", "global toward zero", VEC_W'(fmaRound), 3);
    drive(VECS[10], 3);
    @(negedge clk);
    inValid = 1'b0;
    check(fmaRound == 2'b00, "R8", "embedded nearest", VEC_W'(fmaRound), 0);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule